// File: doc/BRIEF.md
# Clock Mode Decoder and Test Divider

This block turns a three-bit strap configuration (an active-low output enable and two frequency selects) into one of three operating modes for a bank of seven clock groups: CPU, SDRAM, fixed 66 MHz, PCI, 48 MHz, reference and APIC. In release mode every group is switched off and its output enable dropped, so the pads float. In test mode the block clock `clk` acts as the test clock. Each group is produced from it by a fixed even integer division, and the reference group carries the test clock itself. In normal mode the block passes the seven placeholder clocks it is given through unchanged. It also reports a frequency code for the CPU and SDRAM groups, which the synthesizers outside the block use.

The configuration is sampled on every rising edge of `clk`. All test dividers are cleared together whenever the block is outside test mode. On entry to test mode they start in lock-step, so every divided output starts with a full high phase and none begins with a short pulse.

Group bit positions on the vector ports: 0 CPU, 1 SDRAM, 2 fixed 66 MHz, 3 PCI, 4 48 MHz, 5 reference, 6 APIC. Frequency code encoding: 0 = 66 MHz, 1 = 100 MHz, 2 = 133 MHz, 3 = no target.

Top module: `clk_mode_gen`

## Requirements
- R1: With `tri_en_n`=0 and `fsel0`=0 (any `fsel1`) the block is in release mode: `grp_oe` and `grp_clk` are all zero and both frequency codes read 3.
- R2: With `tri_en_n`=0 and `fsel0`=1 (any `fsel1`) the block is in test mode: `grp_oe` is all ones and both frequency codes read 3.
- R3: In test mode bits 0 (CPU) and 1 (SDRAM) of `grp_clk` run at `clk` divided by 4.
- R4: In test mode bit 2 (fixed 66 MHz) runs at `clk` divided by 6, and bits 3 (PCI) and 6 (APIC) run at `clk` divided by 12.
- R5: In test mode bit 4 (48 MHz) runs at `clk` divided by 2 and toggles on every rising edge, and bit 5 (reference) equals `clk` itself.
- R6: In normal mode (`tri_en_n`=1) the codes for {`fsel0`,`fsel1`} are: 00 gives CPU 0 / SDRAM 1; 10 gives 1 / 1; 01 gives 2 / 2; 11 gives 2 / 1.
- R7: In normal mode `grp_oe` is all ones and `grp_clk` equals `norm_clk_in` bit for bit with no clock delay, whatever the selects are.
- R8: When test mode is sampled at edge E, all divided outputs (every bit except 5) rise together at edge E+1, and they are all high together again every 12 edges after that.
- R9: Each divided output with ratio N is high for N/2 edges and then low for N/2 edges.
- R10: Divided outputs are low until the first divider edge of test mode, and leaving test mode clears them, so a re-entry restarts at the phase of R8. Changing `fsel1` while the block stays in test mode does not restart them.
- R11: Configuration inputs take effect only at a rising edge of `clk`: between edges, mode, enables and codes hold their previous values.
- R12: While `rst_n` is low the block is held in release mode (outputs zero, enables zero, codes 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the test clock that is divided in test mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| tri_en_n | input | 1 | Active-low output enable strap; low selects release or test mode |
| fsel0 | input | 1 | Frequency select 0; picks test over release when `tri_en_n` is low |
| fsel1 | input | 1 | Frequency select 1; used only in normal mode |
| norm_clk_in | input | 7 | Placeholder clocks for the seven groups in normal mode |
| grp_clk | output | 7 | Clock value for each group (bit order as above) |
| grp_oe | output | 7 | Output enable for each group pad |
| cpu_fcode | output | 2 | CPU group frequency code |
| sdram_fcode | output | 2 | SDRAM group frequency code |

## Verification
A wrong mode register shows at once at the ports: enables, codes and the source of every group clock all come from it, so a bad decode is visible in the first sample after the edge that loaded it. A divider whose counter or arming flag is wrong shows within one divided period, at most 12 edges. Its bit rises one edge late, or it fails to rise with the others at the common edge, or it keeps a high phase of the wrong length. A divider that is not cleared outside test mode shows only on the next entry to test mode, as a bit that is already high before the first divider edge.

// File: rtl/clkmd_pkg.sv
package clkmd_pkg;

  // number of clock groups and their bit positions on vector ports
  localparam int unsigned NGRP    = 7;
  localparam int unsigned G_CPU   = 0;
  localparam int unsigned G_SDRAM = 1;
  localparam int unsigned G_F66   = 2;
  localparam int unsigned G_PCI   = 3;
  localparam int unsigned G_USB   = 4;
  localparam int unsigned G_REF   = 5;
  localparam int unsigned G_APIC  = 6;

  typedef enum logic [1:0] {
    MD_RELEASE = 2'd0,
    MD_TEST    = 2'd1,
    MD_NORMAL  = 2'd2
  } md_e;

  typedef enum logic [1:0] {
    FC_66   = 2'd0,
    FC_100  = 2'd1,
    FC_133  = 2'd2,
    FC_NONE = 2'd3
  } fc_e;

  typedef struct packed {
    logic tri_n;
    logic f0;
    logic f1;
  } cfg_t;

  // mode from the strap triple
  function automatic md_e md_of(cfg_t c);
    if (c.tri_n)   return MD_NORMAL;
    else if (c.f0) return MD_TEST;
    else           return MD_RELEASE;
  endfunction

  // CPU group frequency target; only meaningful in normal mode
  function automatic fc_e cpu_fc_of(cfg_t c);
    if (!c.tri_n) return FC_NONE;
    case ({c.f0, c.f1})
      2'b00:   return FC_66;
      2'b10:   return FC_100;
      default: return FC_133;
    endcase
  endfunction

  // SDRAM group frequency target; 133 only for the single select pair
  function automatic fc_e sdram_fc_of(cfg_t c);
    if (!c.tri_n) return FC_NONE;
    if (!c.f0 && c.f1) return FC_133;
    return FC_100;
  endfunction

  // divider output level for a given count position within one period
  function automatic logic phase_high(int unsigned pos, int unsigned ratio);
    return pos < (ratio / 2);
  endfunction

endpackage

// File: rtl/clkmd_decode.sv
module clkmd_decode
  import clkmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  output md_e  mode_q,
  output fc_e  cpu_fc_q,
  output fc_e  sdram_fc_q
);

  // configuration takes effect only on a rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MD_RELEASE;
      cpu_fc_q   <= FC_NONE;
      sdram_fc_q <= FC_NONE;
    end else begin
      mode_q     <= md_of(cfg);
      cpu_fc_q   <= cpu_fc_of(cfg);
      sdram_fc_q <= sdram_fc_of(cfg);
    end
  end

endmodule

// File: rtl/clkmd_div.sv
module clkmd_div
  import clkmd_pkg::*;
#(
  parameter int unsigned RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic q
);

  localparam int unsigned CW   = $clog2(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          armed;

  always_comb begin
    cnt_nxt = (cnt == LAST) ? '0 : cnt + CW'(1);
  end

  // cleared whenever not running; first running edge drives the output high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      q     <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      armed <= 1'b0;
      q     <= 1'b0;
    end else if (!armed) begin
      cnt   <= '0;
      armed <= 1'b1;
      q     <= 1'b1;
    end else begin
      cnt   <= cnt_nxt;
      q     <= phase_high(32'(cnt_nxt), RATIO);
    end
  end

endmodule

// File: rtl/clkmd_omux.sv
module clkmd_omux
  import clkmd_pkg::*;
(
  input  md_e             mode,
  input  logic [NGRP-1:0] div_clk,
  input  logic [NGRP-1:0] norm_clk,
  output logic [NGRP-1:0] grp_clk,
  output logic [NGRP-1:0] grp_oe
);

  always_comb begin
    case (mode)
      MD_TEST: begin
        grp_clk = div_clk;
        grp_oe  = '1;
      end
      MD_NORMAL: begin
        grp_clk = norm_clk;
        grp_oe  = '1;
      end
      default: begin
        grp_clk = '0;
        grp_oe  = '0;
      end
    endcase
  end

endmodule

// File: rtl/clk_mode_gen.sv
module clk_mode_gen
  import clkmd_pkg::*;
#(
  parameter int unsigned DIV_CPU   = 4,
  parameter int unsigned DIV_SDRAM = 4,
  parameter int unsigned DIV_F66   = 6,
  parameter int unsigned DIV_PCI   = 12,
  parameter int unsigned DIV_USB   = 2,
  parameter int unsigned DIV_APIC  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tri_en_n,
  input  logic            fsel0,
  input  logic            fsel1,
  input  logic [NGRP-1:0] norm_clk_in,
  output logic [NGRP-1:0] grp_clk,
  output logic [NGRP-1:0] grp_oe,
  output logic [1:0]      cpu_fcode,
  output logic [1:0]      sdram_fcode
);

  // ratio per group, indexed by bit position; ratio 1 means the test clock itself
  localparam int unsigned RATIO_TAB [0:NGRP-1] =
    '{DIV_CPU, DIV_SDRAM, DIV_F66, DIV_PCI, DIV_USB, 1, DIV_APIC};

  cfg_t            cfg;
  md_e             mode_q;
  fc_e             cpu_fc_q;
  fc_e             sdram_fc_q;
  logic            run_en;
  logic [NGRP-1:0] div_clk;

  assign cfg = '{tri_n: tri_en_n, f0: fsel0, f1: fsel1};

  clkmd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .mode_q     (mode_q),
    .cpu_fc_q   (cpu_fc_q),
    .sdram_fc_q (sdram_fc_q)
  );

  // dividers run only while the registered mode is test
  assign run_en = (mode_q == MD_TEST);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (RATIO_TAB[g] >= 2) begin : g_div
      clkmd_div #(.RATIO(RATIO_TAB[g])) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en),
        .q     (div_clk[g])
      );
    end else begin : g_pass
      assign div_clk[g] = clk;
    end
  end

  clkmd_omux u_mux (
    .mode     (mode_q),
    .div_clk  (div_clk),
    .norm_clk (norm_clk_in),
    .grp_clk  (grp_clk),
    .grp_oe   (grp_oe)
  );

  assign cpu_fcode   = cpu_fc_q;
  assign sdram_fcode = sdram_fc_q;

endmodule

// File: rtl/clkmd_sva.sv
module clkmd_sva
  import clkmd_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            tri_en_n,
  input logic            fsel0,
  input logic [NGRP-1:0] norm_clk_in,
  input md_e             mode_q,
  input logic            run_en,
  input logic [NGRP-1:0] div_clk,
  input logic [NGRP-1:0] grp_clk,
  input logic [NGRP-1:0] grp_oe,
  input logic [1:0]      cpu_fcode,
  input logic [1:0]      sdram_fcode
);

  localparam logic [NGRP-1:0] DIV_MASK = ~(NGRP'(1) << G_REF);

  p_release_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RELEASE) |-> (grp_oe == '0 && grp_clk == '0));

  p_sel_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tri_en_n && !fsel0) |=> (mode_q == MD_RELEASE));

  p_sel_test_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tri_en_n && fsel0) |=> (mode_q == MD_TEST && grp_oe == '1));

  p_no_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_NORMAL) |-> (cpu_fcode == 2'd3 && sdram_fcode == 2'd3));

  p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_NORMAL) |-> (grp_clk == norm_clk_in && grp_oe == '1));

  p_common_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |=> ((div_clk & DIV_MASK) == DIV_MASK));

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ((div_clk & DIV_MASK) == '0));

  p_half_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_en) |-> (div_clk[G_USB] != $past(div_clk[G_USB])));

endmodule

bind clk_mode_gen clkmd_sva i_clkmd_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .tri_en_n    (tri_en_n),
  .fsel0       (fsel0),
  .norm_clk_in (norm_clk_in),
  .mode_q      (mode_q),
  .run_en      (run_en),
  .div_clk     (div_clk),
  .grp_clk     (grp_clk),
  .grp_oe      (grp_oe),
  .cpu_fcode   (cpu_fcode),
  .sdram_fcode (sdram_fcode)
);

// File: tb/test_clk_mode_gen.sv
module test_clk_mode_gen;

  localparam int NG = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tri_en_n;
  logic          fsel0;
  logic          fsel1;
  logic [NG-1:0] norm_clk_in;
  logic [NG-1:0] grp_clk;
  logic [NG-1:0] grp_oe;
  logic [1:0]    cpu_fcode;
  logic [1:0]    sdram_fcode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // 50 MHz
  always #10 clk = ~clk;

  clk_mode_gen i_clk_mode_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .tri_en_n    (tri_en_n),
    .fsel0       (fsel0),
    .fsel1       (fsel1),
    .norm_clk_in (norm_clk_in),
    .grp_clk     (grp_clk),
    .grp_oe      (grp_oe),
    .cpu_fcode   (cpu_fcode),
    .sdram_fcode (sdram_fcode)
  );

  // ---------------- reference model (from the requirements) ----------------
  // mode numbers: 0 release, 1 test, 2 normal
  function automatic int tb_mode(logic t, logic f0);
    if (t === 1'b1) return 2;
    return (f0 === 1'b1) ? 1 : 0;
  endfunction

  function automatic int tb_ratio(int g);
    int r;
    r = 12;
    if (g <= 1) r = 4;
    else if (g == 2) r = 6;
    else if (g == 4) r = 2;
    else if (g == 5) r = 1;
    return r;
  endfunction

  function automatic int tb_cpu(logic t, logic f0, logic f1);
    int sel;
    if (t !== 1'b1) return 3;
    sel = (f1 ? 2 : 0) + (f0 ? 1 : 0);
    if (sel == 0) return 0;
    if (sel == 1) return 1;
    return 2;
  endfunction

  function automatic int tb_sdram(logic t, logic f0, logic f1);
    if (t !== 1'b1) return 3;
    return (f1 && !f0) ? 2 : 1;
  endfunction

  int m_mode = 0;
  bit m_run  = 1'b0;
  int m_k    = 0;
  int m_cpu  = 3;
  int m_sd   = 3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= 0; m_run <= 1'b0; m_k <= 0; m_cpu <= 3; m_sd <= 3;
    end else begin
      if (m_mode == 1) begin
        m_k   <= m_run ? m_k + 1 : 0;
        m_run <= 1'b1;
      end else begin
        m_run <= 1'b0;
        m_k   <= 0;
      end
      m_mode <= tb_mode(tri_en_n, fsel0);
      m_cpu  <= tb_cpu(tri_en_n, fsel0, fsel1);
      m_sd   <= tb_sdram(tri_en_n, fsel0, fsel1);
    end
  end

  function automatic logic exp_div(int g);
    int r;
    r = tb_ratio(g);
    if (r == 1) return clk;
    return m_run && ((m_k % r) < (r / 2));
  endfunction

  // ---------------- checking ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t_clk;
    if (m_mode == 0) begin
      chk(grp_oe == '0, "R1 oe", int'(grp_oe), 0);
      chk(cpu_fcode == 2'd3 && sdram_fcode == 2'd3, "R1 codes",
          int'({cpu_fcode, sdram_fcode}), 15);
      chk(grp_clk == '0, "R1 clk", int'(grp_clk), 0);
    end else if (m_mode == 1) begin
      chk(grp_oe == '1, "R2 oe", int'(grp_oe), 127);
      chk(cpu_fcode == 2'd3 && sdram_fcode == 2'd3, "R2 codes",
          int'({cpu_fcode, sdram_fcode}), 15);
      for (int g = 0; g < NG; g++) begin
        if (g <= 1) t_clk = "R3 div4";
        else if (g == 4 || g == 5) t_clk = "R5 div2/ref";
        else t_clk = "R4 div6/12";
        chk(grp_clk[g] === exp_div(g), t_clk, int'(grp_clk[g]), int'(exp_div(g)));
      end
    end else begin
      chk(grp_oe == '1, "R7 oe", int'(grp_oe), 127);
      chk(grp_clk === norm_clk_in, "R7 pass", int'(grp_clk), int'(norm_clk_in));
      chk(int'(cpu_fcode) == m_cpu, "R6 cpu code", int'(cpu_fcode), m_cpu);
      chk(int'(sdram_fcode) == m_sd, "R6 sdram code", int'(sdram_fcode), m_sd);
    end
  endtask

  // one clock: drive at negedge, compare before and after the rising edge
  task automatic cyc(logic t, logic f0, logic f1);
    @(negedge clk);
    tri_en_n    = t;
    fsel0       = f0;
    fsel1       = f1;
    norm_clk_in = NG'($urandom);
    #5 compare_all();
    @(posedge clk);
    #5 compare_all();
  endtask

  localparam logic [NG-1:0] DMASK = 7'b1011111;

  initial begin
    int hi_pci;
    int hi_f66;
    logic [NG-1:0] oe_before;
    void'($urandom(32'h0C1C_2024));
    rst_n = 1'b0; tri_en_n = 1'b1; fsel0 = 1'b0; fsel1 = 1'b0; norm_clk_in = '1;

    // R12: reset state
    repeat (3) @(posedge clk);
    #5;
    chk(grp_oe == '0, "R12 reset oe", int'(grp_oe), 0);
    chk(grp_clk == '0, "R12 reset clk", int'(grp_clk), 0);
    chk(cpu_fcode == 2'd3 && sdram_fcode == 2'd3, "R12 reset codes",
        int'({cpu_fcode, sdram_fcode}), 15);
    @(negedge clk); rst_n = 1'b1;

    // R6/R7: all four select pairs in normal mode
    for (int p = 0; p < 4; p++) repeat (3) cyc(1'b1, p[0], p[1]);

    // R1: release with both fsel1 values
    repeat (3) cyc(1'b0, 1'b0, 1'b0);
    repeat (3) cyc(1'b0, 1'b0, 1'b1);

    // R10: first sample in test mode, dividers still low
    cyc(1'b0, 1'b1, 1'b0);
    chk((grp_clk & DMASK) == '0, "R10 low before start", int'(grp_clk & DMASK), 0);
    // R8: next edge all divided outputs rise together
    cyc(1'b0, 1'b1, 1'b0);
    chk((grp_clk & DMASK) == DMASK, "R8 common rise", int'(grp_clk & DMASK), int'(DMASK));
    // R9: duty over one full 12-edge period starting at the common rise
    hi_pci = int'(grp_clk[3]);
    hi_f66 = int'(grp_clk[2]);
    for (int i = 1; i < 12; i++) begin
      cyc(1'b0, 1'b1, 1'b0);
      hi_pci += int'(grp_clk[3]);
      if (i < 6) hi_f66 += int'(grp_clk[2]);
    end
    chk(hi_pci == 6, "R9 pci high count", hi_pci, 6);
    chk(hi_f66 == 3, "R9 f66 high count", hi_f66, 3);
    cyc(1'b0, 1'b1, 1'b0);
    chk((grp_clk & DMASK) == DMASK, "R8 realign at 12", int'(grp_clk & DMASK), int'(DMASK));
    // R10: fsel1 toggles in test mode without restart
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    chk(m_k == 14 && grp_clk[0] === exp_div(0), "R10 no restart on fsel1",
        int'(grp_clk[0]), int'(exp_div(0)));

    // R11: input change is not visible before the edge
    @(negedge clk);
    oe_before = grp_oe;
    tri_en_n = 1'b0; fsel0 = 1'b0;
    #5;
    chk(grp_oe == oe_before, "R11 hold until edge", int'(grp_oe), int'(oe_before));
    @(posedge clk); #5;
    chk(grp_oe == '0, "R11 after edge", int'(grp_oe), 0);

    // R10: re-entry restarts from low
    cyc(1'b0, 1'b1, 1'b1);
    chk((grp_clk & DMASK) == '0, "R10 re-entry low", int'(grp_clk & DMASK), 0);
    cyc(1'b0, 1'b1, 1'b1);
    chk((grp_clk & DMASK) == DMASK, "R8 re-entry rise", int'(grp_clk & DMASK), int'(DMASK));

    // random segments
    for (int s = 0; s < 80; s++) begin
      logic [2:0] c;
      int len;
      c   = 3'($urandom);
      len = 1 + int'($urandom % 20);
      repeat (len) begin
        cyc(c[2], c[1], c[0]);
        if (m_mode == 1 && m_run && (m_k % 12) == 0)
          chk((grp_clk & DMASK) == DMASK, "R8 random realign", int'(grp_clk & DMASK), int'(DMASK));
      end
    end

    // R12: reset during test mode
    repeat (5) cyc(1'b0, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk(grp_oe == '0 && grp_clk == '0, "R12 async reset", int'(grp_oe), 0);
    @(posedge clk); #5;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) cyc(1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule